// File: doc/BRIEF.md
# Link-Tracking Slave Command Register

This block is the command register of an interior device with two links, such as a pass-through tunnel, in a daisy-chained packet fabric that may carry a host at each end. Configuration reads and writes reach it tagged with the link they arrived on, 0 or 1. The register notes on its own which link faces the master host. It also holds a direction bit set by software and a base unit ID field.

From the recorded master-host link and the direction bit it drives `req_link`. This output names the link on which requests that start inside the device leave it. A build parameter turns the block into a single-link variant, in which the direction bit no longer affects routing.

Configuration accesses are single-cycle strobes. The block takes one on every cycle and never applies back-pressure. Read data is valid in the same cycle as a read strobe.

Top module: `slvcmd_reg`

## Requirements
- R1: A write with `cfg_be[1]` set loads bit 10 (master-host link) of the register with `cfg_link` on the next clock edge. The value of `cfg_wdata[10]` is discarded, because the arrival link takes priority over it.
- R2: A write with `cfg_be[1]` set loads bit 11 (direction) from `cfg_wdata[11]`.
- R3: A write with `cfg_be[0]` set loads bits 4:0 (base unit ID) from `cfg_wdata[4:0]`.
- R4: A field whose byte lane is disabled keeps its value. A cycle with `cfg_valid` low, or a read, changes no field.
- R5: Warm reset (`rst_n` low) clears the master-host bit, the direction bit and the unit ID to 0.
- R6: In the two-link build, `req_link` equals master-host bit XOR direction bit. Direction 0 sends requests toward the master host.
- R7: In the single-link build (`SINGLE_LINK`=1), `req_link` is always 0, whatever the direction bit holds.
- R8: During a read (`cfg_valid`=1, `cfg_write`=0), `cfg_rdata` returns the unit ID in bits 4:0, the master-host bit in bit 10 and the direction bit in bit 11, with all other bits 0. In every other cycle `cfg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_link | input | 1 | Link the access arrived on |
| cfg_be | input | 2 | Byte enables for the write data |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, 0 when not reading |
| req_link | output | 1 | Link for locally originated requests |

## Verification
The hardest case to reach is a write whose bit 10 data disagrees with its arrival link while the upper byte is enabled. Only this case shows whether the captured link, rather than the data, wins. The sweep crosses every arrival link with every byte-enable pattern, and with write data whose bit 10 is set and cleared. Each write is followed by a read on both builds, so the link priority and the effect of each lane are observed at the ports.

// File: rtl/slvcmd_pkg.sv
package slvcmd_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned UID_W   = 5;
  localparam int unsigned MH_POS  = 10;
  localparam int unsigned DIR_POS = 11;
  localparam int unsigned BE_W    = REG_W / 8;

  typedef struct packed {
    logic             dir;
    logic             mhost;
    logic [UID_W-1:0] uid;
  } slvcmd_fields_t;
endpackage

// File: rtl/slvcmd_field_wr.sv
module slvcmd_field_wr
  import slvcmd_pkg::*;
(
  input  logic             wr_en,
  input  logic [BE_W-1:0]  be,
  input  logic [REG_W-1:0] wdata,
  input  logic             link,
  input  slvcmd_fields_t   cur,
  output slvcmd_fields_t   nxt
);
  localparam int unsigned HI_LANE = DIR_POS / 8;
  localparam int unsigned LO_LANE = 0;

  always_comb begin
    nxt = cur;
    if (wr_en) begin
      if (be[LO_LANE]) nxt.uid = wdata[UID_W-1:0];
      if (be[HI_LANE]) begin
        nxt.dir   = wdata[DIR_POS];
        nxt.mhost = link;
      end
    end
  end
endmodule

// File: rtl/slvcmd_route.sv
module slvcmd_route #(
  parameter bit SINGLE_LINK = 1'b0
) (
  input  logic mhost,
  input  logic dir,
  output logic req_link
);
  generate
    if (SINGLE_LINK) begin : g_one
      logic unused_in;
      assign unused_in = mhost ^ dir;
      assign req_link  = 1'b0;
    end else begin : g_two
      assign req_link = mhost ^ dir;
    end
  endgenerate
endmodule

// File: rtl/slvcmd_reg.sv
module slvcmd_reg
  import slvcmd_pkg::*;
#(
  parameter bit SINGLE_LINK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_write,
  input  logic             cfg_link,
  input  logic [BE_W-1:0]  cfg_be,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             req_link
);
  slvcmd_fields_t fld_q, fld_d;
  logic           wr_en, rd_en;
  logic [REG_W-1:0] img;

  assign wr_en = cfg_valid & cfg_write;
  assign rd_en = cfg_valid & ~cfg_write;

  slvcmd_field_wr u_wr (
    .wr_en (wr_en),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .link  (cfg_link),
    .cur   (fld_q),
    .nxt   (fld_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= '0;
    else        fld_q <= fld_d;
  end

  always_comb begin
    img                = '0;
    img[UID_W-1:0]     = fld_q.uid;
    img[MH_POS]        = fld_q.mhost;
    img[DIR_POS]       = fld_q.dir;
  end

  assign cfg_rdata = rd_en ? img : '0;

  slvcmd_route #(.SINGLE_LINK(SINGLE_LINK)) u_route (
    .mhost    (fld_q.mhost),
    .dir      (fld_q.dir),
    .req_link (req_link)
  );
endmodule

// File: rtl/slvcmd_reg_chk.sv
module slvcmd_reg_chk
  import slvcmd_pkg::*;
#(
  parameter bit SINGLE_LINK = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_write,
  input logic             cfg_link,
  input logic [BE_W-1:0]  cfg_be,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             req_link,
  input slvcmd_fields_t   fld_q
);
  AST_LINK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write && cfg_be[1]) |=> (fld_q.mhost == $past(cfg_link))); // R1
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write && cfg_be[1]) |=> (fld_q.dir == $past(cfg_wdata[DIR_POS]))); // R2
  AST_UID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write && cfg_be[0]) |=> (fld_q.uid == $past(cfg_wdata[UID_W-1:0]))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_write) |=> $stable(fld_q)); // R4
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && !cfg_write) |-> (cfg_rdata == '0)); // R8
  generate
    if (SINGLE_LINK) begin : g_one
      AST_ONE_LINK_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        req_link == 1'b0); // R7
    end else begin : g_two
      AST_TWO_LINK_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        req_link == (fld_q.mhost ^ fld_q.dir)); // R6
    end
  endgenerate
endmodule

bind slvcmd_reg slvcmd_reg_chk #(.SINGLE_LINK(SINGLE_LINK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_write (cfg_write),
  .cfg_link  (cfg_link),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .req_link  (req_link),
  .fld_q     (fld_q)
);

// File: tb/slvcmd_reg_bench.sv
module slvcmd_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_write = 1'b0;
  logic        cfg_link = 1'b0;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] rdata_two, rdata_one;
  logic        link_two, link_one;

  int vectors = 0;
  int fails   = 0;
  logic       e_m, e_d;
  logic [4:0] e_uid;

  always #(CLK_PERIOD/2) clk = ~clk;

  slvcmd_reg #(.SINGLE_LINK(1'b0)) u_slvcmd_reg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_link(cfg_link), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_two), .req_link(link_two));

  slvcmd_reg #(.SINGLE_LINK(1'b1)) u_slvcmd_reg_one (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_link(cfg_link), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_one), .req_link(link_one));

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] image();
    return {4'b0, e_d, e_m, 5'b0, e_uid};
  endfunction

  // Issue one access cycle from a negedge; register updates at the next posedge.
  task automatic access(input logic v, input logic w, input logic l,
                        input logic [1:0] be, input logic [15:0] wd);
    @(negedge clk);
    cfg_valid = v; cfg_write = w; cfg_link = l; cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0; cfg_be = 2'b00; cfg_wdata = '0;
  endtask

  // Read and compare both builds; sampled 1 time unit after inputs settle.
  task automatic read_check(input string tag);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b0; cfg_link = 1'b1;
    #1;
    check16({tag, " R8 two-link rdata"}, rdata_two, image());
    check16({tag, " R8 one-link rdata"}, rdata_one, image());
    check16({tag, " R6 req_link"}, {15'b0, link_two}, {15'b0, e_m ^ e_d});
    check16({tag, " R7 req_link single"}, {15'b0, link_one}, 16'h0);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    check16({tag, " R8 rdata idle"}, rdata_two, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    e_m = 1'b0; e_d = 1'b0; e_uid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_check("reset R5");

    for (int l = 0; l < 2; l++) begin
      for (int be = 0; be < 4; be++) begin
        for (int p = 0; p < 8; p++) begin
          logic [15:0] wd;
          wd = '0;
          wd[10] = p[0] ? ~l[0] : l[0];
          wd[11] = p[1];
          wd[4:0] = 5'(p * 7 + l * 3 + be + 1);
          wd[15:12] = 4'hF; wd[9:5] = 5'h1F;
          access(1'b1, 1'b1, l[0], be[1:0], wd);
          if (be[0]) e_uid = wd[4:0];          // R3
          if (be[1]) begin e_d = wd[11]; e_m = l[0]; end // R1 R2, R4 otherwise
          read_check("sweep R1 R2 R3 R4");
        end
      end
    end

    // Strobe low with write asserted, then a pure read: no change (R4).
    access(1'b0, 1'b1, ~e_m, 2'b11, 16'hFFFF ^ image());
    read_check("valid low R4");
    access(1'b1, 1'b0, ~e_m, 2'b11, 16'hFFFF);
    read_check("read no effect R4");

    // Warm reset mid-run (R5).
    access(1'b1, 1'b1, 1'b1, 2'b11, 16'h0815);
    e_m = 1'b1; e_d = 1'b1; e_uid = 5'h15;
    read_check("pre-reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    e_m = 1'b0; e_d = 1'b0; e_uid = '0;
    read_check("warm reset R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule